// File: doc/BRIEF.md
# Multi-level standby power sequencer

This block decides how deeply a gated logic domain sleeps and takes it there one step at a time. A requested mode is one of four: run, nap, doze or sleep. Each deeper mode adds steps to the one before it. Nap parks the domain's combinational inputs on a programmable low-leakage vector and then stops the module clock. Doze also switches the PLL off. Sleep then raises output isolation, pulses a retention save and opens the supply switch. A wake event brings the domain back to run. Waking undoes the same steps in reverse order and waits for the analog acknowledgements: power-good before the retention restore, and PLL lock before the clock is enabled again.

Entering a low-power mode first waits a programmable delay that belongs to the target mode, so deep entries can be made slower than shallow ones. A wake that arrives during an entry aborts it at the next step boundary and unwinds it. A request that arrives while a transition is running is held and carried out once the transition completes. The reported mode changes only when a sequence has fully completed.

Top module: `pwr_standby_seq`

## Requirements
- R1: Mode codes on `req_mode` and `cur_mode` are 0 = run, 1 = nap, 2 = doze, 3 = sleep. After reset, `cur_mode` is 0, `clk_en` and `pll_en` are 1, and `force_en`, `iso_en`, `sw_off`, `ret_save` and `ret_restore` are 0.
- R2: Entering nap raises `force_en` first and drops `clk_en` exactly one cycle later. `pll_en` stays 1.
- R3: Entering doze performs the nap steps and then drops `pll_en` exactly one cycle after `clk_en` falls.
- R4: Entering sleep performs the doze steps. After them, `iso_en` rises one cycle after `pll_en` falls, a one-cycle `ret_save` pulse follows in the next cycle, and `sw_off` rises in the cycle after that. `iso_en` stays 1 for as long as `sw_off` is 1.
- R5: `dom_in` equals `park_vec` while `force_en` is 1, and equals `func_in` otherwise.
- R6: A request for a deeper mode that is accepted on a clock edge raises `force_en` exactly D+2 cycles after that edge. D is the delay input for the target mode (`dly_nap`, `dly_doze` or `dly_sleep`).
- R7: Waking from sleep proceeds in this order. `sw_off` falls first. `ret_restore` pulses only after `pwr_good` has been seen high. `iso_en` falls the cycle after the restore. `pll_en` rises next. `clk_en` rises only after `pll_lock` has been seen high. `force_en` falls the cycle after `clk_en` rises.
- R8: A wake during an entry delay leaves every control output at its run value. A wake during entry steps allows at most one further step and then unwinds the sequence. In neither case does `cur_mode` report the aborted mode.
- R9: A request that arrives during a transition is held, and only the latest one is kept. It is served after the transition completes. A wake discards any held request.
- R10: `cur_mode` takes the new mode one cycle after the last step of a sequence, and never earlier.
- R11: While `clk_en` is 0, `force_en` is 1. While `pll_en` is 0, `clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| wake | input | 1 | Wake event, returns to run |
| pll_lock | input | 1 | PLL lock acknowledgement |
| pwr_good | input | 1 | Domain supply good acknowledgement |
| dly_nap | input | CNT_W | Entry delay, nap |
| dly_doze | input | CNT_W | Entry delay, doze |
| dly_sleep | input | CNT_W | Entry delay, sleep |
| park_vec | input | DATA_W | Low-leakage input vector |
| func_in | input | DATA_W | Functional inputs for the domain |
| dom_in | output | DATA_W | Inputs delivered to the domain |
| clk_en | output | 1 | Module clock enable |
| pll_en | output | 1 | PLL enable |
| force_en | output | 1 | Input parking active |
| iso_en | output | 1 | Output isolation active |
| ret_save | output | 1 | One-cycle retention save pulse |
| ret_restore | output | 1 | One-cycle retention restore pulse |
| sw_off | output | 1 | Supply switch open |
| cur_mode | output | 2 | Mode reached by the last completed sequence |

## Verification
Two functions can coincide in the same cycle. A wake event can arrive on the very edge where an entry step is being taken, and a held request can be launched on the edge where a sequence settles. The bench covers the first case by pulsing `wake` in the cycle `iso_en` rises. It then requires that the save step still happens, that the switch never opens, that a restore pulse unwinds the state, and that `cur_mode` never reports sleep. For the second case, the bench stacks two requests behind a doze entry. It then checks that only the later one is reported, right after doze, and that a wake issued together with a held request drops that request.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_NAP   = 2'd1,
    MD_DOZE  = 2'd2,
    MD_SLEEP = 2'd3
  } pmode_e;

  // Step depth: each value adds one applied power-down step.
  localparam logic [2:0] LV_NONE   = 3'd0;
  localparam logic [2:0] LV_FORCE  = 3'd1;
  localparam logic [2:0] LV_CGATE  = 3'd2;
  localparam logic [2:0] LV_PLLOFF = 3'd3;
  localparam logic [2:0] LV_ISO    = 3'd4;
  localparam logic [2:0] LV_SAVED  = 3'd5;
  localparam logic [2:0] LV_CUT    = 3'd6;

  function automatic logic [2:0] depth_of(pmode_e m);
    case (m)
      MD_NAP:   return LV_CGATE;
      MD_DOZE:  return LV_PLLOFF;
      MD_SLEEP: return LV_CUT;
      default:  return LV_NONE;
    endcase
  endfunction

  // An upward step from this depth may only be taken once its acknowledge is in.
  function automatic logic rise_ok(logic [2:0] lv, logic lock, logic pg);
    if (lv == LV_SAVED) return pg;
    if (lv == LV_CGATE) return lock;
    return 1'b1;
  endfunction

endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             active
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cancel) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= val;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pss_arb.sv
module pss_arb import pss_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  pmode_e           req_mode,
  input  logic             wake,
  input  logic             settled,
  input  logic [2:0]       cur_lvl,
  input  logic [CNT_W-1:0] dly_nap,
  input  logic [CNT_W-1:0] dly_doze,
  input  logic [CNT_W-1:0] dly_sleep,
  output pmode_e           tgt,
  output logic             launch,
  output logic             dly_load,
  output logic [CNT_W-1:0] dly_val
);

  pmode_e pend_mode;
  pmode_e nxt;
  logic   pend_v;

  function automatic logic [CNT_W-1:0] pick_delay(pmode_e m, logic [CNT_W-1:0] a,
                                                  logic [CNT_W-1:0] b, logic [CNT_W-1:0] c);
    case (m)
      MD_NAP:   return a;
      MD_DOZE:  return b;
      MD_SLEEP: return c;
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    nxt      = req_valid ? req_mode : pend_mode;
    launch   = !wake && settled && (req_valid || pend_v);
    dly_load = launch && (depth_of(nxt) > cur_lvl);
    dly_val  = pick_delay(nxt, dly_nap, dly_doze, dly_sleep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt       <= MD_RUN;
      pend_mode <= MD_RUN;
      pend_v    <= 1'b0;
    end else if (wake) begin
      tgt    <= MD_RUN;
      pend_v <= 1'b0;
    end else if (launch) begin
      tgt    <= nxt;
      pend_v <= 1'b0;
    end else if (req_valid) begin
      pend_v    <= 1'b1;
      pend_mode <= req_mode;
    end
  end

endmodule

// File: rtl/pss_seq.sv
module pss_seq import pss_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [2:0] tgt_lvl,
  input  logic       pll_lock,
  input  logic       pwr_good,
  output logic [2:0] lvl,
  output logic       save_p,
  output logic       restore_p
);

  logic step_dn;
  logic step_up;

  always_comb begin
    step_dn = !hold && (lvl < tgt_lvl);
    step_up = !hold && (lvl > tgt_lvl) && rise_ok(lvl, pll_lock, pwr_good);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl       <= LV_NONE;
      save_p    <= 1'b0;
      restore_p <= 1'b0;
    end else begin
      if (step_dn)      lvl <= lvl + 3'd1;
      else if (step_up) lvl <= lvl - 3'd1;
      save_p    <= step_dn && (lvl == LV_ISO);
      restore_p <= step_up && (lvl == LV_SAVED);
    end
  end

endmodule

// File: rtl/pwr_standby_seq.sv
module pwr_standby_seq import pss_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              wake,
  input  logic              pll_lock,
  input  logic              pwr_good,
  input  logic [CNT_W-1:0]  dly_nap,
  input  logic [CNT_W-1:0]  dly_doze,
  input  logic [CNT_W-1:0]  dly_sleep,
  input  logic [DATA_W-1:0] park_vec,
  input  logic [DATA_W-1:0] func_in,
  output logic [DATA_W-1:0] dom_in,
  output logic              clk_en,
  output logic              pll_en,
  output logic              force_en,
  output logic              iso_en,
  output logic              ret_save,
  output logic              ret_restore,
  output logic              sw_off,
  output logic [1:0]        cur_mode
);

  pmode_e           tgt;
  logic [2:0]       lvl;
  logic [2:0]       tgt_lvl;
  logic             dly_act;
  logic             dly_load;
  logic [CNT_W-1:0] dly_val;
  logic             launch;
  logic             settled;

  assign tgt_lvl = depth_of(tgt);
  assign settled = !dly_act && (lvl == tgt_lvl);

  pss_arb #(.CNT_W(CNT_W)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (pmode_e'(req_mode)),
    .wake      (wake),
    .settled   (settled),
    .cur_lvl   (lvl),
    .dly_nap   (dly_nap),
    .dly_doze  (dly_doze),
    .dly_sleep (dly_sleep),
    .tgt       (tgt),
    .launch    (launch),
    .dly_load  (dly_load),
    .dly_val   (dly_val)
  );

  pss_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cancel (wake),
    .load   (dly_load),
    .val    (dly_val),
    .active (dly_act)
  );

  pss_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (dly_act),
    .tgt_lvl   (tgt_lvl),
    .pll_lock  (pll_lock),
    .pwr_good  (pwr_good),
    .lvl       (lvl),
    .save_p    (ret_save),
    .restore_p (ret_restore)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_mode <= MD_RUN;
    else if (settled) cur_mode <= tgt;
  end

  always_comb begin
    force_en = (lvl >= LV_FORCE);
    clk_en   = (lvl <  LV_CGATE);
    pll_en   = (lvl <  LV_PLLOFF);
    iso_en   = (lvl >= LV_ISO);
    sw_off   = (lvl >= LV_CUT);
  end

  assign dom_in = force_en ? park_vec : func_in;

endmodule

// File: rtl/pss_checker.sv
module pss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_lock,
  input logic       pwr_good,
  input logic       clk_en,
  input logic       pll_en,
  input logic       force_en,
  input logic       iso_en,
  input logic       ret_save,
  input logic       ret_restore,
  input logic       sw_off,
  input logic [1:0] cur_mode
);

  a_r11_gate_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> force_en);

  a_r11_pll_off_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !clk_en);

  a_r4_iso_covers_cut: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |-> iso_en);

  a_r4_save_single: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |=> !ret_save);

  a_r4_save_under_iso: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |-> (iso_en && !sw_off));

  a_r4_cut_after_save: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_off) |-> $past(ret_save));

  a_r7_restore_after_pg: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |-> $past(pwr_good));

  a_r7_clk_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(pll_lock));

  a_r10_sleep_report: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_mode) && cur_mode == 2'd3) |-> (sw_off && iso_en));

  a_r10_run_report: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_mode) && cur_mode == 2'd0) |-> (clk_en && pll_en && !force_en && !iso_en));

endmodule

bind pwr_standby_seq pss_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pll_lock    (pll_lock),
  .pwr_good    (pwr_good),
  .clk_en      (clk_en),
  .pll_en      (pll_en),
  .force_en    (force_en),
  .iso_en      (iso_en),
  .ret_save    (ret_save),
  .ret_restore (ret_restore),
  .sw_off      (sw_off),
  .cur_mode    (cur_mode)
);

// File: tb/pwr_standby_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_standby_seq_tb_top;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;
  localparam int PG_LAT = 6;
  localparam int LK_LAT = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_mode;
  logic              wake;
  logic              pll_lock;
  logic              pwr_good;
  logic [CNT_W-1:0]  dly_nap, dly_doze, dly_sleep;
  logic [DATA_W-1:0] park_vec, func_in, dom_in;
  logic              clk_en, pll_en, force_en, iso_en, ret_save, ret_restore, sw_off;
  logic [1:0]        cur_mode;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  int exp_q[$];
  int t_req, t_force_r, t_force_f, t_cg_f, t_clk_r, t_pll_f, t_pll_r;
  int t_iso_r, t_iso_f, t_save, t_restore, t_sw_r, t_sw_f, t_mode, t_pg_r, t_lock_r;
  int n_sw_r = 0, n_save = 0, n_inv = 0, mode_at_sw_r;

  always #10 clk = ~clk;

  pwr_standby_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake(wake), .pll_lock(pll_lock), .pwr_good(pwr_good),
    .dly_nap(dly_nap), .dly_doze(dly_doze), .dly_sleep(dly_sleep),
    .park_vec(park_vec), .func_in(func_in), .dom_in(dom_in),
    .clk_en(clk_en), .pll_en(pll_en), .force_en(force_en), .iso_en(iso_en),
    .ret_save(ret_save), .ret_restore(ret_restore), .sw_off(sw_off),
    .cur_mode(cur_mode)
  );

  task automatic chk_eq(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic issue(int m, bit expect_report);
    @(negedge clk);
    req_mode  = m[1:0];
    req_valid = 1'b1;
    if (expect_report) exp_q.push_back(m);
    @(negedge clk);
    t_req     = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wake_pulse(bit expect_report);
    wake = 1'b1;
    if (expect_report) exp_q.push_back(0);
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic wait_mode(string rq, int m);
    for (int i = 0; i < 3000; i++) begin
      if (cur_mode == m[1:0]) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk_eq(rq, "mode reached", int'(cur_mode), m);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Acknowledge models for the supply switch and the PLL
  initial begin
    int pg_cnt, lk_cnt;
    pwr_good = 1'b1; pll_lock = 1'b1; pg_cnt = PG_LAT; lk_cnt = LK_LAT;
    forever begin
      @(negedge clk);
      if (sw_off) begin pg_cnt = 0; pwr_good = 1'b0; end
      else if (pg_cnt < PG_LAT) pg_cnt++;
      else if (!pwr_good) begin pwr_good = 1'b1; t_pg_r = cyc; end
      if (!pll_en) begin lk_cnt = 0; pll_lock = 1'b0; end
      else if (lk_cnt < LK_LAT) lk_cnt++;
      else if (!pll_lock) begin pll_lock = 1'b1; t_lock_r = cyc; end
    end
  end

  // Monitor: event stamps, invariant count and mode scoreboard
  initial begin
    logic p_force, p_clk, p_pll, p_iso, p_sw;
    logic [1:0] p_mode;
    p_force = 0; p_clk = 1; p_pll = 1; p_iso = 0; p_sw = 0; p_mode = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (force_en && !p_force) t_force_r = cyc;
      if (!force_en && p_force) t_force_f = cyc;
      if (!clk_en && p_clk) t_cg_f = cyc;
      if (clk_en && !p_clk) t_clk_r = cyc;
      if (!pll_en && p_pll) t_pll_f = cyc;
      if (pll_en && !p_pll) t_pll_r = cyc;
      if (iso_en && !p_iso) t_iso_r = cyc;
      if (!iso_en && p_iso) t_iso_f = cyc;
      if (ret_save) begin t_save = cyc; n_save++; end
      if (ret_restore) t_restore = cyc;
      if (sw_off && !p_sw) begin t_sw_r = cyc; n_sw_r++; mode_at_sw_r = cur_mode; end
      if (!sw_off && p_sw) t_sw_f = cyc;
      if ((!clk_en && !force_en) || (!pll_en && clk_en) || (sw_off && !iso_en)) n_inv++;
      if (cur_mode != p_mode) begin
        t_mode = cyc;
        if (exp_q.size() == 0) chk_eq("R10", "unexpected mode report", int'(cur_mode), int'(p_mode));
        else chk_eq("R10", "reported mode", int'(cur_mode), exp_q.pop_front());
      end
      p_force = force_en; p_clk = clk_en; p_pll = pll_en; p_iso = iso_en;
      p_sw = sw_off; p_mode = cur_mode;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int saved_force, saved_sw;
    rst_n = 0; req_valid = 0; req_mode = 0; wake = 0;
    dly_nap = 4; dly_doze = 6; dly_sleep = 9;
    park_vec = 8'hA5; func_in = 8'h3C;
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    chk_eq("R1", "cur_mode", int'(cur_mode), 0);
    chk_eq("R1", "clk_en/pll_en", int'({clk_en, pll_en}), 3);
    chk_eq("R1", "force/iso/sw", int'({force_en, iso_en, sw_off}), 0);
    chk_eq("R1", "save/restore", int'({ret_save, ret_restore}), 0);
    chk_eq("R5", "dom_in in run", int'(dom_in), 8'h3C);

    // Nap
    issue(1, 1);
    wait_mode("R2", 1);
    chk_eq("R6", "nap entry delay", t_force_r - t_req, 6);
    chk_eq("R2", "clock gate one cycle after force", t_cg_f - t_force_r, 1);
    chk_eq("R2", "pll stays on", int'(pll_en), 1);
    chk_eq("R10", "report after gate", t_mode - t_cg_f, 1);
    chk_eq("R5", "dom_in parked", int'(dom_in), 8'hA5);
    func_in = 8'h5A;
    @(negedge clk);
    chk_eq("R5", "parked against input change", int'(dom_in), 8'hA5);
    wake_pulse(1);
    wait_mode("R7", 0);
    chk_eq("R7", "release after clock on", t_force_f - t_clk_r, 1);
    chk_eq("R5", "dom_in released", int'(dom_in), 8'h5A);

    // Doze
    issue(2, 1);
    wait_mode("R3", 2);
    chk_eq("R6", "doze entry delay", t_force_r - t_req, 8);
    chk_eq("R3", "pll off after gate", t_pll_f - t_cg_f, 1);
    wake_pulse(1);
    wait_mode("R7", 0);
    chk_eq("R7", "clock waits for lock", int'(t_clk_r > t_lock_r), 1);
    chk_eq("R7", "lock latency respected", int'(t_clk_r - t_pll_r >= LK_LAT), 1);

    // Sleep
    issue(3, 1);
    wait_mode("R4", 3);
    chk_eq("R6", "sleep entry delay", t_force_r - t_req, 11);
    chk_eq("R4", "iso after pll off", t_iso_r - t_pll_f, 1);
    chk_eq("R4", "save after iso", t_save - t_iso_r, 1);
    chk_eq("R4", "cut after save", t_sw_r - t_save, 1);
    chk_eq("R10", "mode at cut", mode_at_sw_r, 0);
    chk_eq("R10", "report after cut", t_mode - t_sw_r, 1);
    idle(10);
    chk_eq("R4", "iso held while cut", int'({iso_en, sw_off}), 3);
    chk_eq("R5", "parked in sleep", int'(dom_in), 8'hA5);
    wake_pulse(1);
    wait_mode("R7", 0);
    chk_eq("R7", "switch on before pg", int'(t_sw_f < t_pg_r), 1);
    chk_eq("R7", "restore after pg", int'(t_restore > t_pg_r), 1);
    chk_eq("R7", "iso off after restore", t_iso_f - t_restore, 1);
    chk_eq("R7", "clock after lock", int'(t_clk_r > t_lock_r), 1);

    // R8 abort during entry delay
    saved_force = t_force_r; saved_sw = n_sw_r;
    issue(3, 0);
    idle(4);
    wake_pulse(0);
    idle(30);
    chk_eq("R8", "no step during aborted delay", t_force_r, saved_force);
    chk_eq("R8", "run outputs kept", int'({clk_en, pll_en, force_en, iso_en, sw_off}), 5'b11000);
    chk_eq("R8", "mode stays run", int'(cur_mode), 0);

    // R8 abort during steps: wake on the cycle isolation rises
    dly_sleep = 0;
    saved_sw = n_sw_r;
    issue(3, 0);
    for (int i = 0; i < 100; i++) begin
      if (iso_en) break;
      @(negedge clk);
    end
    wake_pulse(0);
    for (int i = 0; i < 200; i++) begin
      if (!force_en) break;
      @(negedge clk);
    end
    idle(3);
    chk_eq("R8", "switch never opened", n_sw_r, saved_sw);
    chk_eq("R8", "unwound with restore", int'(t_restore > t_save), 1);
    chk_eq("R8", "back to run outputs", int'({clk_en, pll_en, force_en, iso_en}), 4'b1100);
    chk_eq("R8", "mode stays run", int'(cur_mode), 0);

    // R9 held requests, latest wins
    dly_sleep = 9;
    saved_sw = n_sw_r;
    issue(2, 1);
    issue(3, 0);
    issue(1, 1);
    wait_mode("R9", 2);
    wait_mode("R9", 1);
    chk_eq("R9", "nap outputs after held request", int'({clk_en, pll_en}), 1);
    chk_eq("R9", "overwritten sleep not served", n_sw_r, saved_sw);
    wake_pulse(1);
    wait_mode("R9", 0);

    // R9 wake drops a held request
    issue(3, 0);
    issue(1, 0);
    wake_pulse(0);
    idle(40);
    chk_eq("R9", "held request dropped by wake", int'({cur_mode, force_en}), 0);

    chk_eq("R11", "ordering invariant violations", n_inv, 0);
    chk_eq("R10", "unserved expected reports", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule